// File: doc/BRIEF.md
# Fifth-Order Sinc Decimation Filter

This block turns the one-bit output stream of a delta-sigma modulator into signed 24-bit conversion words. An internal divider produces a modulator sample strobe every six system clocks. On each strobe the incoming bit is taken as +1 or -1 and fed to a chain of five integrators. Every 64th sample, five comb stages difference the integrator output. The comb result is scaled down by 2^7 and clamped into the 24-bit two's complement range. One output word is produced every 384 system clocks.

The cascade needs five full output periods before its window holds only fresh samples. The block therefore counts outputs after every restart. It raises a settled flag with the fifth one, and only then issues a one-clock result strobe. A restart can come from the synchronous reset, from a synchronous clear input, or from a change of the channel-select input. The channel select is sampled on the falling clock edge. A restart zeroes all filter state and the settle count, and returns the outputs to their reset values.

Top module: `sinc5_decim`

## Requirements
- R1: While `rst` is high, and on the first falling edge after it is released, `result` is 0, `result_vld` is 0 and `settled` is 0.
- R2: Modulator samples are taken on every sixth rising clock edge after a restart. The first is the sixth edge and the next comes six edges later. One filter output is formed for every 64 samples, so outputs are spaced 384 clocks apart.
- R3: Each output equals floor(y / 128), where y is the input stream (bit 1 = +1, bit 0 = -1, samples before the restart = 0) passed through five cascaded running sums of 64 samples. y is evaluated at the 64th, 128th, ... sample after the restart.
- R4: A value above +8388607 after scaling is delivered as 0x7FFFFF, and a value below -8388608 as 0x800000. An all-ones input therefore settles at 0x7FFFFF and an all-zeros input at 0x800000.
- R5: `settled` rises together with the fifth output after a restart and stays high until the next restart. `result_vld` is never high while `settled` is low.
- R6: When settled, `result_vld` is high for exactly one clock. It rises on the second rising edge after the edge that takes the 64th sample of the output. `result` holds the new word in that cycle.
- R7: A value of `chan_sel` captured on a falling clock edge that differs from the previous capture restarts the filter at the next rising edge. A change that is undone before the falling edge has no effect.
- R8: `flt_clear` high at a rising edge restarts the filter at that edge.
- R9: After any restart, `result` reads 0 and `settled` and `result_vld` read 0 until new outputs arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| chan_sel | input | CHAN_W (2) | Channel select; a change restarts the filter |
| flt_clear | input | 1 | Synchronous filter restart |
| result | output | OUT_W (24) | Scaled, saturated conversion word, two's complement |
| result_vld | output | 1 | One-clock strobe for a settled result |
| settled | output | 1 | Five outputs produced since the last restart |

## Verification
The bench builds the block with its default parameters: divide-by-6 strobe, ratio 64, order 5, 24-bit output and 2-bit select. These give 32-bit accumulators, a full-scale comb magnitude of exactly 2^30 and a scale shift of 7. A constant input therefore lands exactly on the positive clamp boundary, while quarter-duty patterns land at 0x400000 and 0xC00000. With ratio 64 and order 5, the settle window of 320 samples, the 384-clock output spacing and a mid-conversion channel or clear restart all fit into a few tens of thousands of cycles.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

  // Bit growth of an order-N cascade with decimation ratio R.
  function automatic int growth_bits(input int order, input int ratio);
    return order * $clog2(ratio);
  endfunction

  // Width of a counter that must reach the given limit.
  function automatic int count_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/sinc_rate.sv
module sinc_rate #(
  parameter int CLK_DIV = 6,
  parameter int DECIM   = 64
) (
  input  logic clk,
  input  logic clr,
  output logic stb,
  output logic dec
);
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int DEC_W = $clog2(DECIM);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(DECIM - 1);

  logic [DIV_W-1:0] div_q;
  logic [DEC_W-1:0] smp_q;
  logic             dec_q;

  assign stb = (div_q == DIV_LAST);
  assign dec = dec_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      div_q <= '0;
      smp_q <= '0;
      dec_q <= 1'b0;
    end else begin
      div_q <= stb ? '0 : div_q + DIV_W'(1);
      if (stb) smp_q <= (smp_q == DEC_LAST) ? '0 : smp_q + DEC_W'(1);
      dec_q <= stb && (smp_q == DEC_LAST);
    end
  end

  // R2: the sample strobe never lasts two clocks.
  assert_stb_gap_R2: assert property (@(posedge clk) disable iff (clr)
    stb |=> !stb);

  // R2: a decimation pulse only follows a sample strobe.
  assert_dec_follows_R2: assert property (@(posedge clk) disable iff (clr)
    dec |-> $past(stb));

endmodule

// File: rtl/sinc_integ.sv
module sinc_integ #(
  parameter int ORDER = 5,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    stb,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] acc_out
);
  localparam logic signed [ACC_W-1:0] PLUS_ONE  = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINUS_ONE = '1;

  logic signed [ACC_W-1:0] x_val;
  assign x_val = bit_in ? PLUS_ONE : MINUS_ONE;

  // All stages advance on the same strobe; each sees the freshly
  // summed value of the stage before it, so the cascade has no delay.
  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_d;
    if (s == 0) begin : g_head
      assign acc_d = acc_q + x_val;
    end else begin : g_tail
      assign acc_d = acc_q + g_stage[s-1].acc_d;
    end
    always_ff @(posedge clk) begin
      if (clr)      acc_q <= '0;
      else if (stb) acc_q <= acc_d;
    end
  end

  assign acc_out = g_stage[ORDER-1].acc_q;

  // R3: the first integrator moves by exactly one step per sample.
  assert_head_step_R3: assert property (@(posedge clk) disable iff (clr)
    stb |=> ((g_stage[0].acc_q - $past(g_stage[0].acc_q) == PLUS_ONE) ||
             (g_stage[0].acc_q - $past(g_stage[0].acc_q) == MINUS_ONE)));

endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
  parameter int ORDER = 5,
  parameter int ACC_W = 32,
  parameter int GROW  = 30
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    dec,
  input  logic signed [ACC_W-1:0] acc_in,
  output logic signed [ACC_W-1:0] comb_out,
  output logic                    comb_vld
);
  localparam longint BOUND = longint'(1) <<< GROW;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic signed [ACC_W-1:0] src;
    logic signed [ACC_W-1:0] dly_q;
    logic signed [ACC_W-1:0] diff;
    if (s == 0) begin : g_head
      assign src = acc_in;
    end else begin : g_tail
      assign src = g_stage[s-1].diff;
    end
    assign diff = src - dly_q;
    always_ff @(posedge clk) begin
      if (clr)      dly_q <= '0;
      else if (dec) dly_q <= src;
    end
  end

  logic signed [ACC_W-1:0] out_q;
  logic                    vld_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= dec;
      if (dec) out_q <= g_stage[ORDER-1].diff;
    end
  end

  assign comb_out = out_q;
  assign comb_vld = vld_q;

  // R3: with +/-1 inputs the comb result never exceeds ratio^order.
  assert_comb_bound_R3: assert property (@(posedge clk) disable iff (clr)
    vld_q |-> ((longint'(out_q) <= BOUND) && (longint'(out_q) >= -BOUND)));

endmodule

// File: rtl/sinc_out.sv
module sinc_out #(
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 24,
  parameter int SHIFT  = 7,
  parameter int SETTLE = 5
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    in_vld,
  input  logic signed [ACC_W-1:0] in_val,
  output logic [OUT_W-1:0]        result,
  output logic                    result_vld,
  output logic                    settled
);
  localparam int CNT_W = sinc_pkg::count_bits(SETTLE);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(SETTLE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);
  localparam logic signed [ACC_W-1:0] POS_LIM =
    ACC_W'((longint'(1) <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM =
    ACC_W'(-(longint'(1) <<< (OUT_W - 1)));
  localparam logic [OUT_W-1:0] POS_FULL = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_FULL = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] scaled;
  logic [OUT_W-1:0]        sat_val;

  assign scaled = in_val >>> SHIFT;

  always_comb begin
    if (scaled > POS_LIM)      sat_val = POS_FULL;
    else if (scaled < NEG_LIM) sat_val = NEG_FULL;
    else                       sat_val = scaled[OUT_W-1:0];
  end

  logic [CNT_W-1:0] cnt_q;
  logic [OUT_W-1:0] res_q;
  logic             vld_q;
  logic             set_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
      set_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (in_vld) begin
        res_q <= sat_val;
        if (cnt_q < CNT_TOP) cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q >= CNT_LAST) begin
          vld_q <= 1'b1;
          set_q <= 1'b1;
        end
      end
    end
  end

  assign result     = res_q;
  assign result_vld = vld_q;
  assign settled    = set_q;

  // R6: the result strobe lasts one clock.
  assert_vld_pulse_R6: assert property (@(posedge clk) disable iff (clr)
    vld_q |=> !vld_q);

  // R5: no result strobe without the settled flag.
  assert_vld_settled_R5: assert property (@(posedge clk) disable iff (clr)
    vld_q |-> set_q);

  // R5: once settled, the flag holds until a restart.
  assert_settle_hold_R5: assert property (@(posedge clk) disable iff (clr)
    set_q |=> set_q);

  // R4: an over-range positive value is clamped to full scale.
  assert_pos_clamp_R4: assert property (@(posedge clk) disable iff (clr)
    (in_vld && (scaled > POS_LIM)) |=> (res_q == POS_FULL));

  // R4: an over-range negative value is clamped to negative full scale.
  assert_neg_clamp_R4: assert property (@(posedge clk) disable iff (clr)
    (in_vld && (scaled < NEG_LIM)) |=> (res_q == NEG_FULL));

endmodule

// File: rtl/sinc5_decim.sv
module sinc5_decim #(
  parameter int CLK_DIV = 6,
  parameter int DECIM   = 64,
  parameter int ORDER   = 5,
  parameter int OUT_W   = 24,
  parameter int CHAN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_bit,
  input  logic [CHAN_W-1:0] chan_sel,
  input  logic              flt_clear,
  output logic [OUT_W-1:0]  result,
  output logic              result_vld,
  output logic              settled
);
  localparam int IN_W  = 2;
  localparam int GROW  = sinc_pkg::growth_bits(ORDER, DECIM);
  localparam int ACC_W = IN_W + GROW;
  localparam int SHIFT = GROW - (OUT_W - 1);

  // Channel select is captured on the falling edge, compared on the rising one.
  logic [CHAN_W-1:0] ch_neg;
  logic [CHAN_W-1:0] ch_q;
  logic              chan_chg;
  logic              restart;

  always_ff @(negedge clk) ch_neg <= chan_sel;

  always_ff @(posedge clk) ch_q <= ch_neg;

  assign chan_chg = !rst && (ch_neg != ch_q);
  assign restart  = rst || flt_clear || chan_chg;

  logic                    stb;
  logic                    dec;
  logic signed [ACC_W-1:0] acc_last;
  logic signed [ACC_W-1:0] comb_val;
  logic                    comb_vld;

  sinc_rate #(.CLK_DIV(CLK_DIV), .DECIM(DECIM)) u_rate (
    .clk(clk), .clr(restart), .stb(stb), .dec(dec)
  );

  sinc_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .clr(restart), .stb(stb), .bit_in(mod_bit), .acc_out(acc_last)
  );

  sinc_comb #(.ORDER(ORDER), .ACC_W(ACC_W), .GROW(GROW)) u_comb (
    .clk(clk), .clr(restart), .dec(dec), .acc_in(acc_last),
    .comb_out(comb_val), .comb_vld(comb_vld)
  );

  sinc_out #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT), .SETTLE(ORDER)) u_out (
    .clk(clk), .clr(restart), .in_vld(comb_vld), .in_val(comb_val),
    .result(result), .result_vld(result_vld), .settled(settled)
  );

  // R9: any restart leaves cleared outputs behind it.
  assert_restart_clear_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> ((result == '0) && !settled && !result_vld));

  // R7: a detected channel change drops the settled flag.
  assert_chan_restart_R7: assert property (@(posedge clk) disable iff (rst)
    chan_chg |=> !settled);

  // R8: the clear input drops the settled flag.
  assert_clear_restart_R8: assert property (@(posedge clk) disable iff (rst)
    flt_clear |=> !settled);

endmodule

// File: tb/sim_sinc5_decim.sv
`timescale 1ns/1ps
module sim_sinc5_decim;
  localparam int STAGES   = 5;
  localparam int RATIO    = 64;
  localparam int DIV      = 6;
  localparam int SCALE_SH = 7;
  localparam int WD_LIMIT = 150000;

  typedef struct packed {
    int          code;
    int          nout;
    logic [23:0] expv;
    bit          chk;
  } vec_t;

  // pattern code, outputs to run, expected last settled word, compare flag
  localparam vec_t VECS [6] = '{
    '{0, 6, 24'h7FFFFF, 1'b1},
    '{1, 6, 24'h800000, 1'b1},
    '{2, 6, 24'h000000, 1'b1},
    '{3, 7, 24'h000000, 1'b0},
    '{4, 6, 24'h400000, 1'b1},
    '{5, 6, 24'hC00000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_bit = 1'b0;
  logic [1:0]  chan_sel = 2'd0;
  logic        flt_clear = 1'b0;
  logic [23:0] result;
  logic        result_vld;
  logic        settled;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  sinc5_decim #(.CLK_DIV(DIV), .DECIM(RATIO), .ORDER(STAGES), .OUT_W(24), .CHAN_W(2)) u0 (
    .clk(clk), .rst(rst), .mod_bit(mod_bit), .chan_sel(chan_sel),
    .flt_clear(flt_clear), .result(result), .result_vld(result_vld),
    .settled(settled)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL R2 watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Reference model: five cascaded 64-sample running sums.
  longint win [STAGES][RATIO];
  int     wpos;

  function automatic void model_clear();
    for (int s = 0; s < STAGES; s++)
      for (int j = 0; j < RATIO; j++) win[s][j] = 0;
    wpos = 0;
  endfunction

  function automatic longint model_push(input bit b);
    longint v = b ? 64'sd1 : -64'sd1;
    for (int s = 0; s < STAGES; s++) begin
      win[s][wpos] = v;
      v = 0;
      for (int j = 0; j < RATIO; j++) v += win[s][j];
    end
    wpos = (wpos + 1) % RATIO;
    return v;
  endfunction

  function automatic logic [23:0] model_sat(input longint y);
    longint q = y >>> SCALE_SH;
    if (q > 64'sd8388607)  return 24'h7FFFFF;
    if (q < -64'sd8388608) return 24'h800000;
    return q[23:0];
  endfunction

  function automatic bit pat(input int code, input int k);
    case (code)
      0:       return 1'b1;
      1:       return 1'b0;
      2:       return (k % 2) == 0;
      3:       return k >= 200;
      4:       return (k % 4) != 3;
      default: return (k % 4) == 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_cleared(input string req);
    check(result == 24'h0, req, "result after restart", result, 0);
    check(!settled, req, "settled after restart", settled, 0);
    check(!result_vld, req, "strobe after restart", result_vld, 0);
  endtask

  // Restart via the clear input; ends at the falling edge after the restart edge.
  task automatic do_clear();
    @(negedge clk); flt_clear = 1'b1;
    @(posedge clk);
    @(negedge clk); flt_clear = 1'b0;
  endtask

  // Drives samples without checking (ends at a falling edge).
  task automatic push_some(input int code, input int n);
    for (int k = 0; k < n; k++) begin
      mod_bit = pat(code, k);
      repeat (DIV) @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Runs a pattern from a fresh restart and checks every cycle (R2, R3, R5, R6).
  task automatic run_pattern(input int code, input int nout, output logic [23:0] last);
    int          n_samp = nout * RATIO;
    int          outs = 0;
    bit          pend = 1'b0;
    bit          exp_set = 1'b0;
    logic [23:0] pend_val = '0;
    longint      y = 0;
    last = '0;
    model_clear();
    for (int k = 0; k <= n_samp; k++) begin
      if (k < n_samp) begin
        mod_bit = pat(code, k);
        y = model_push(mod_bit);
      end
      for (int c = 1; c <= DIV; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (c == 2 && pend) exp_set = 1'b1;
        check(result_vld == (pend && c == 2), "R6", "strobe timing", result_vld, pend && c == 2);
        check(settled == exp_set, "R5", "settled flag", settled, exp_set);
        if (pend && c == 2) begin
          check(result == pend_val, "R3", "filter output", result, pend_val);
          last = result;
        end
      end
      pend = 1'b0;
      if (k < n_samp && (k % RATIO) == RATIO - 1) begin
        outs = outs + 1;
        pend = (outs >= STAGES);
        pend_val = model_sat(y);
      end
    end
  endtask

  initial begin
    logic [23:0] last;
    // R1: reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(result == 24'h0 && !result_vld && !settled, "R1", "outputs in reset",
          {result_vld, settled, result}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(result == 24'h0 && !result_vld && !settled, "R1", "outputs after release",
          {result_vld, settled, result}, 0);

    // Table of patterns (R2, R3, R4, R5, R6)
    for (int i = 0; i < 6; i++) begin
      do_clear();
      run_pattern(VECS[i].code, VECS[i].nout, last);
      if (VECS[i].chk) begin
        if (VECS[i].expv == 24'h7FFFFF || VECS[i].expv == 24'h800000)
          check(last == VECS[i].expv, "R4", "clamped steady word", last, VECS[i].expv);
        else
          check(last == VECS[i].expv, "R3", "steady word", last, VECS[i].expv);
      end
    end

    // R8 and R9: clear input in the middle of settled operation
    do_clear();
    push_some(0, STAGES * RATIO + 40);
    check(settled, "R5", "settled before clear", settled, 1);
    check(result == 24'h7FFFFF, "R4", "word before clear", result, 24'h7FFFFF);
    do_clear();
    check_cleared("R9");
    run_pattern(1, 5, last);
    check(last == 24'h800000, "R8", "first word after clear", last, 24'h800000);

    // R7: channel change mid-conversion
    push_some(0, STAGES * RATIO + 10);
    check(settled, "R5", "settled before channel change", settled, 1);
    @(posedge clk); #5 chan_sel = 2'd2;
    @(posedge clk);
    @(negedge clk);
    check_cleared("R7");
    run_pattern(4, 6, last);
    check(last == 24'h400000, "R7", "word after channel change", last, 24'h400000);

    // R7: a select glitch removed before the falling edge is ignored
    push_some(0, 8);
    check(settled, "R7", "settled before glitch", settled, 1);
    @(posedge clk); #2 chan_sel = 2'd1; #4 chan_sel = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(settled, "R7", "settled after glitch", settled, 1);

    // R1: synchronous reset in the middle of operation
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(result == 24'h0 && !result_vld && !settled, "R1", "outputs during reset",
          {result_vld, settled, result}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(result == 24'h0 && !result_vld && !settled, "R1", "outputs after reset",
          {result_vld, settled, result}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule